// File: doc/BRIEF.md
# Mode-Switchable Receive Character Queue

This block is the receive-side character store of a serial port. A receiver, or a loopback path, pushes 12-bit entries: a character in the low eight bits and per-character error status in the upper four. The host drains the queue one entry per data-register read. A mode bit sets how much the queue holds. With the bit set, the queue is a circular buffer of `DEPTH` slots, where `DEPTH` is a power of two. With the bit clear, it holds a single entry. Any change of the mode bit empties the queue.

Each pop copies the status nibble of the departing entry into a status register. The host clears that register with a write strobe. A dedicated strobe enqueues a break marker. The block drives empty and full flags and a free-space count. It also raises a level-style receive request when the count reaches the trigger level of one. The request drops when a pop brings the count below that level.

The head entry is always visible on `pop_entry_o`, so a host read returns it in the same cycle as the pop strobe. The reset input is asynchronous and active low, and its release is synchronized inside the block across two clock edges.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, the queue is in single-entry mode: `empty_o`=1, `full_o`=0, `space_o`=1, `rx_irq_o`=0, `stat_o`=0, and every storage slot reads as zero on `pop_entry_o`.
- R2: The effective depth is `DEPTH` when the registered mode is 1 and 1 when it is 0. `space_o` always equals the effective depth minus the entry count.
- R3: Entries leave in the order they were accepted. `pop_entry_o` shows the entry at the read slot. Pushes go to slot (read slot + count) modulo the effective depth, and a pop advances the read slot modulo the effective depth.
- R4: `empty_o` is 1 exactly when the count is 0. `full_o` is 1 exactly when the count equals the effective depth.
- R5: In any cycle where `fifo_en_i` differs from the registered mode, the count and read slot return to zero and the new mode takes effect on the next edge. Push, break and pop requests in that cycle are ignored, and `rx_irq_o` keeps its value.
- R6: A push or break while full is dropped, and the stored entries and count stay unchanged.
- R7: A pop while empty leaves the count and read slot unchanged, and `pop_entry_o` keeps showing the same entry.
- R8: A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged while both the write and read positions advance.
- R9: `brk_i` enqueues the entry 0x400 (bit 10 set, data zero). When `brk_i` and `push_i` are both high, the break entry wins and the `push_i` data is discarded.
- R10: A pop that is not ignored under R5, including a pop while empty, loads bits 11:8 of the head entry into `stat_o` on the next edge. `stat_clr_i` without a pop clears `stat_o`, and the pop capture wins when both are high.
- R11: `rx_irq_o` sets when an accepted push, with no accepted pop, brings the count to 1. It clears when a pop, with no accepted push, leaves the count at 0, and this includes a pop while empty. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | Queue mode: 1 = DEPTH slots, 0 = one slot |
| push_i | input | 1 | Enqueue `push_entry_i` |
| push_entry_i | input | 12 | Entry to enqueue: status 11:8, character 7:0 |
| brk_i | input | 1 | Enqueue a break marker (0x400) |
| pop_i | input | 1 | Host data read: dequeue head |
| stat_clr_i | input | 1 | Host write to the status register: clear it |
| pop_entry_o | output | 12 | Entry at the read slot |
| empty_o | output | 1 | Queue holds no entries |
| full_o | output | 1 | Count equals effective depth |
| space_o | output | $clog2(DEPTH+1) | Free slots |
| stat_o | output | 4 | Status nibble of the last popped entry |
| rx_irq_o | output | 1 | Receive request level |

## Verification
A corrupted count shows on the next clock edge as a mismatch between `empty_o`, `full_o` and `space_o` and the number of entries the host has pushed and popped. A stray read slot shows on `pop_entry_o` within the same cycle, because the head is read without a register in between. A lost or duplicated write shows only when that slot reaches the head, which can be up to `DEPTH` pops later. For that reason the bench keeps a slot-accurate model of the queue and compares every output on every cycle, across long mixed sequences in both modes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W  = 8;
  localparam int STAT_W  = 4;
  localparam int ENTRY_W = DATA_W + STAT_W;
  localparam int BRK_BIT = 10;
  localparam int RX_TRIG = 1;

  typedef struct packed {
    logic [STAT_W-1:0] stat;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam logic [STAT_W-1:0] BRK_STAT = STAT_W'(1 << (BRK_BIT - DATA_W));
  localparam rx_entry_t BRK_ENTRY = '{stat: BRK_STAT, data: '0};
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wslot_i,
  input  rx_entry_t        wdata_i,
  input  logic [PTR_W-1:0] rslot_i,
  output rx_entry_t        rdata_o
);

  rx_entry_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = we_i && (wslot_i == PTR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_we) begin
        slot_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = slot_q[rslot_i];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             push_req_i,
  input  logic             pop_req_i,
  output logic             flush_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             pop_empty_o,
  output logic [PTR_W-1:0] wslot_o,
  output logic [PTR_W-1:0] rslot_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] space_o
);

  logic             mode_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, eff;
  logic [PTR_W-1:0] rptr_q, rptr_d, mask;
  logic             st_en;

  // next-state
  always_comb begin
    flush_o     = mode_i ^ mode_q;
    eff         = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
    mask        = mode_q ? PTR_W'(DEPTH - 1) : '0;
    push_ok_o   = ~flush_o & push_req_i & (cnt_q != eff);
    pop_ok_o    = ~flush_o & pop_req_i & (cnt_q != '0);
    pop_empty_o = ~flush_o & pop_req_i & (cnt_q == '0);
    wslot_o     = (rptr_q + cnt_q[PTR_W-1:0]) & mask;

    cnt_d  = cnt_q;
    rptr_d = rptr_q;
    if (flush_o) begin
      cnt_d  = '0;
      rptr_d = '0;
    end else begin
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
      if (pop_ok_o) rptr_d = (rptr_q + PTR_W'(1)) & mask;
    end
    st_en = flush_o | push_ok_o | pop_ok_o;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
      rptr_q <= '0;
    end else begin
      mode_q <= mode_i;
      if (st_en) begin
        cnt_q  <= cnt_d;
        rptr_q <= rptr_d;
      end
    end
  end

  assign rslot_o   = rptr_q;
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == eff);
  assign space_o   = eff - cnt_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= eff);

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != mode_q) |=> (empty_o && rptr_q == '0));

  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_req_i && !pop_req_i && mode_i == mode_q)
      |=> ($stable(cnt_q) && full_o));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_req_i && !push_req_i && mode_i == mode_q)
      |=> ($stable(rptr_q) && empty_o));

  // R8
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && !full_o && push_req_i && pop_req_i && mode_i == mode_q)
      |=> $stable(cnt_q));

endmodule

// File: rtl/rxq_report.sv
module rxq_report
  import rxq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [STAT_W-1:0] head_stat_i,
  input  logic              clr_i,
  input  logic              push_ok_i,
  input  logic              pop_ok_i,
  input  logic              pop_empty_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);

  localparam logic [CNT_W-1:0] TRIG_LVL = CNT_W'(RX_TRIG);
  localparam logic [CNT_W-1:0] TRIG_LO  = CNT_W'(RX_TRIG - 1);

  logic [STAT_W-1:0] stat_q, stat_d;
  logic              stat_en;
  logic              irq_q, irq_d, irq_set, irq_clr;

  // next-state
  always_comb begin
    stat_en = cap_i | clr_i;
    stat_d  = cap_i ? head_stat_i : '0;
    irq_set = push_ok_i & ~pop_ok_i & (cnt_nxt_i == TRIG_LVL);
    irq_clr = (pop_ok_i | pop_empty_i) & ~push_ok_i & (cnt_nxt_i == TRIG_LO);
    irq_d   = irq_set ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      irq_q <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !cap_i) |=> (stat_o == '0));

  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !cap_i) |=> $stable(stat_o));

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (cnt_i == TRIG_LVL));

  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> (cnt_i == TRIG_LO));

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en_i,
  input  logic               push_i,
  input  logic [ENTRY_W-1:0] push_entry_i,
  input  logic               brk_i,
  input  logic               pop_i,
  input  logic               stat_clr_i,
  output logic [ENTRY_W-1:0] pop_entry_o,
  output logic               empty_o,
  output logic               full_o,
  output logic [CNT_W-1:0]   space_o,
  output logic [STAT_W-1:0]  stat_o,
  output logic               rx_irq_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic             flush, push_ok, pop_ok, pop_empty;
  logic [PTR_W-1:0] wslot, rslot;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  rx_entry_t        wr_entry, head;

  // R9: break marker takes priority over pushed data
  assign wr_entry = brk_i ? BRK_ENTRY : rx_entry_t'(push_entry_i);

  rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .mode_i      (fifo_en_i),
    .push_req_i  (push_i | brk_i),
    .pop_req_i   (pop_i),
    .flush_o     (flush),
    .push_ok_o   (push_ok),
    .pop_ok_o    (pop_ok),
    .pop_empty_o (pop_empty),
    .wslot_o     (wslot),
    .rslot_o     (rslot),
    .cnt_o       (cnt),
    .cnt_nxt_o   (cnt_nxt),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .space_o     (space_o)
  );

  rxq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we_i    (push_ok),
    .wslot_i (wslot),
    .wdata_i (wr_entry),
    .rslot_i (rslot),
    .rdata_o (head)
  );

  rxq_report #(.CNT_W(CNT_W)) u_report (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cap_i       (pop_ok | pop_empty),
    .head_stat_i (head.stat),
    .clr_i       (stat_clr_i),
    .push_ok_i   (push_ok),
    .pop_ok_i    (pop_ok),
    .pop_empty_i (pop_empty),
    .cnt_i       (cnt),
    .cnt_nxt_i   (cnt_nxt),
    .stat_o      (stat_o),
    .irq_o       (rx_irq_o)
  );

  assign pop_entry_o = head;

  // R4
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(empty_o && full_o));

  // R5
  flush_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |=> $stable(rx_irq_o));

endmodule

// File: tb/rx_char_queue_bench.sv
module rx_char_queue_bench;
  localparam int D  = 8;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, fifo_en_i, push_i, brk_i, pop_i, stat_clr_i;
  logic [11:0]   push_entry_i, pop_entry_o;
  logic          empty_o, full_o, rx_irq_o;
  logic [CW-1:0] space_o;
  logic [3:0]    stat_o;

  rx_char_queue #(.DEPTH(D)) u_rx_char_queue (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en_i), .push_i(push_i),
    .push_entry_i(push_entry_i), .brk_i(brk_i), .pop_i(pop_i),
    .stat_clr_i(stat_clr_i), .pop_entry_o(pop_entry_o), .empty_o(empty_o),
    .full_o(full_o), .space_o(space_o), .stat_o(stat_o), .rx_irq_o(rx_irq_o)
  );

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";

  // model of the queue built from the requirements
  logic [11:0] mm [D];
  int          mcnt, mrp;
  logic        men, mirq;
  logic [3:0]  mstat;

  task automatic chk(input string f, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, f, act, exp);
    end
  endtask

  task automatic compare();
    int eff;
    eff = men ? D : 1;
    chk("empty", int'(empty_o), int'(mcnt == 0));
    chk("full",  int'(full_o),  int'(mcnt == eff));
    chk("space", int'(space_o), eff - mcnt);
    chk("entry", int'(pop_entry_o), int'(mm[mrp]));
    chk("stat",  int'(stat_o), int'(mstat));
    chk("irq",   int'(rx_irq_o), int'(mirq));
  endtask

  task automatic model_step(input logic p, input logic [11:0] e, input logic b,
                            input logic o, input logic en, input logic c);
    int eff, ncnt;
    logic ap, pok, ook;
    logic [11:0] ent, hd;
    eff = men ? D : 1;
    if (en != men) begin
      mcnt = 0;
      mrp  = 0;
      if (c) mstat = 4'h0;
    end else begin
      ap  = p | b;
      ent = b ? 12'h400 : e;
      pok = ap && (mcnt != eff);
      ook = o && (mcnt != 0);
      hd  = mm[mrp];
      if (pok) mm[(mrp + mcnt) % eff] = ent;
      if (o) mstat = hd[11:8];
      else if (c) mstat = 4'h0;
      ncnt = mcnt + int'(pok) - int'(ook);
      if (pok && !ook && ncnt == 1) mirq = 1'b1;
      else if (o && !pok && ncnt == 0) mirq = 1'b0;
      if (ook) mrp = (mrp + 1) % eff;
      mcnt = ncnt;
    end
    men = en;
  endtask

  // one cycle: check state, drive, clock, update model
  task automatic cyc(input logic p, input logic [11:0] e, input logic b,
                     input logic o, input logic en, input logic c);
    compare();
    push_i = p; push_entry_i = e; brk_i = b; pop_i = o;
    fifo_en_i = en; stat_clr_i = c;
    @(posedge clk);
    model_step(p, e, b, o, en, c);
    @(negedge clk);
  endtask

  task automatic idle(input logic en);
    cyc(1'b0, 12'h0, 1'b0, 1'b0, en, 1'b0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog %s actual=running expected=finished", tag);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] lf;
    logic        en_s;
    for (int i = 0; i < D; i++) mm[i] = 12'h0;
    mcnt = 0; mrp = 0; men = 1'b0; mirq = 1'b0; mstat = 4'h0;
    rst_n = 1'b0; fifo_en_i = 1'b0; push_i = 1'b0; brk_i = 1'b0;
    pop_i = 1'b0; stat_clr_i = 1'b0; push_entry_i = 12'h0;
    repeat (3) @(negedge clk);
    // R1 reset values
    tag = "R1";
    chk("reset empty", int'(empty_o), 1);
    chk("reset full", int'(full_o), 0);
    chk("reset space", int'(space_o), 1);
    chk("reset irq", int'(rx_irq_o), 0);
    chk("reset stat", int'(stat_o), 0);
    chk("reset entry", int'(pop_entry_o), 0);
    rst_n = 1'b1;
    repeat (3) idle(1'b0);

    // R2 single-entry mode
    tag = "R2";
    cyc(1'b1, 12'h341, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("single full", int'(full_o), 1);
    chk("single space", int'(space_o), 0);
    tag = "R6";
    cyc(1'b1, 12'h0AA, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("dropped push keeps head", int'(pop_entry_o), 12'h341);
    tag = "R10";
    cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("stat after pop", int'(stat_o), 4'h3);

    // R5 switch mode with simultaneous push ignored
    tag = "R5";
    cyc(1'b1, 12'h155, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("flush empty", int'(empty_o), 1);
    chk("flush space", int'(space_o), D);

    // R4 fill to full with distinct entries, R6 overflow
    tag = "R4";
    for (int i = 0; i < D; i++) cyc(1'b1, 12'(i * 17 + 12'h105), 1'b0, 1'b0, 1'b1, 1'b0);
    chk("full after fill", int'(full_o), 1);
    tag = "R6";
    cyc(1'b1, 12'hFFF, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("still full", int'(full_o), 1);

    // R3 drain in order
    tag = "R3";
    for (int i = 0; i < D; i++) begin
      chk("order", int'(pop_entry_o), int'(12'(i * 17 + 12'h105)));
      cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b1, 1'b0);
    end

    // R7 pop while empty
    tag = "R7";
    cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("empty pop", int'(empty_o), 1);

    // R8 simultaneous push and pop, wrapping the pointers
    tag = "R8";
    for (int i = 0; i < 3; i++) cyc(1'b1, 12'(12'h020 + i), 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 2 * D; i++) cyc(1'b1, 12'(12'h230 + i), 1'b0, 1'b1, 1'b1, 1'b0);
    chk("level kept", int'(space_o), D - 3);
    for (int i = 0; i < 3; i++) cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b1, 1'b0);

    // R9 break marker, priority over push data
    tag = "R9";
    cyc(1'b1, 12'h2EE, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("break entry", int'(pop_entry_o), 12'h400);
    cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("break stat", int'(stat_o), 4'h4);

    // R10 clear, and capture winning over clear
    tag = "R10";
    cyc(1'b0, 12'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("stat cleared", int'(stat_o), 0);
    cyc(1'b1, 12'h9C3, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("capture wins", int'(stat_o), 4'h9);

    // R11 irq kept through flush, dropped by pop while empty
    tag = "R11";
    cyc(1'b1, 12'h011, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("irq set", int'(rx_irq_o), 1);
    cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("irq held across flush", int'(rx_irq_o), 1);
    cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("irq cleared", int'(rx_irq_o), 0);

    // long mixed sweep, both modes
    tag = "R3";
    lf   = 16'hACE1;
    en_s = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      logic fill;
      lf   = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 700 == 699) en_s = ~en_s;
      fill = ((i / 200) % 2) == 0;
      cyc(fill ? (lf[1:0] != 2'b00) : (lf[1:0] == 2'b00),
          {lf[15:12], lf[9:2]},
          lf[7:4] == 4'h0,
          fill ? (lf[3:2] == 2'b00) : (lf[3:2] != 2'b00),
          en_s,
          lf[11:8] == 4'h0);
    end
    compare();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule